// File: doc/BRIEF.md
# Source-Stamping Message Endpoint

This block connects one attached agent to a packet-switched on-chip control network. The agent may be a processor thread, a peripheral or an untrusted third-party core. Every control message is four 32-bit words. The first word is a header that carries a 16-bit origin address in its upper half and a 16-bit target address in its lower half. The remaining three words are opaque to the endpoint; by convention an opcode sits in the top byte of word 1.

On the send side, the endpoint takes a whole message in one handshake. It replaces the origin field with its own address, whatever the agent wrote there, and then streams the four words onto the outgoing link, one per accepted cycle. A start-of-frame flag marks the header word. On the receive side, it assembles frames from the incoming link and keeps only those addressed to itself. It hands each kept message to the agent together with the true origin, which the agent can use for access decisions. Frames addressed elsewhere are discarded and counted.

The endpoint's own address comes from a configuration input that is captured while reset is held. For a process hosted on a processor, this input would be a subnet prefix joined to the thread number.

Top module: `msg_endpoint`

## Requirements
- R1: After reset, `tx_ready` is 1, `lo_valid` is 0, `rx_valid` is 0, `li_ready` is 1 and `drop_count` is 0.
- R2: In every transmitted header word (`lo_sof`=1), bits [31:16] equal the local address and bits [15:0] equal `tx_msg[15:0]`. The value the agent placed in `tx_msg[31:16]` never appears. Words 1 to 3 equal `tx_msg[63:32]`, `tx_msg[95:64]` and `tx_msg[127:96]` unchanged.
- R3: A message leaves as four link transfers in word order 0,1,2,3. One word moves per cycle with `lo_valid` and `lo_ready` both high. `lo_sof` is 1 only on word 0. While `lo_valid` is high and `lo_ready` is low, `lo_data` and `lo_sof` hold their values.
- R4: `tx_ready` is 0 from the cycle after a `tx_valid`/`tx_ready` handshake until the fourth word has been taken by the link. It is 1 again in the following cycle. `lo_valid` is never high while `tx_ready` is high.
- R5: The local address is the value on `cfg_addr` at a clock edge with `rst` high. Changing `cfg_addr` after reset has no effect on transmitted headers or on receive filtering.
- R6: A received frame whose header bits [15:0] equal the local address is presented on `rx_msg`, with word 0 in bits [31:0]. `rx_valid` is 1 and `rx_src` carries header bits [31:16]. These are held until a cycle with `rx_ready` high.
- R7: A complete received frame whose header bits [15:0] differ from the local address is not presented. `drop_count` rises by one on the cycle after its last word. The count saturates at its all-ones value.
- R8: While a kept message waits for the agent, `li_ready` is 0. Kept messages reach the agent in the order they arrived on the link.
- R9: A word with `li_sof`=0 that arrives outside a frame is discarded and not counted. A word with `li_sof`=1 always starts a new frame, abandoning any partly assembled one.
- R10: Messages accepted from the agent leave on the link in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures `cfg_addr` |
| cfg_addr | input | 16 | Endpoint address, sampled only during reset |
| tx_valid | input | 1 | Agent offers a message |
| tx_ready | output | 1 | Endpoint can accept a message |
| tx_msg | input | 128 | Message from agent, word 0 in bits [31:0] |
| lo_valid | output | 1 | Outgoing link word valid |
| lo_ready | input | 1 | Outgoing link accepts the word |
| lo_sof | output | 1 | Outgoing word is a header |
| lo_data | output | 32 | Outgoing link word |
| li_valid | input | 1 | Incoming link word valid |
| li_ready | output | 1 | Endpoint accepts the incoming word |
| li_sof | input | 1 | Incoming word is a header |
| li_data | input | 32 | Incoming link word |
| rx_valid | output | 1 | Kept message waiting for agent |
| rx_ready | input | 1 | Agent takes the message |
| rx_msg | output | 128 | Received message, word 0 in bits [31:0] |
| rx_src | output | 16 | True origin of the received message |
| drop_count | output | 8 | Saturating count of frames addressed elsewhere |

## Verification
The assertions assume that the link and the agent follow a valid/ready discipline. They also assume that reset is held for more than one cycle, so that the count and the captured address are defined before the first check. The bench drives every input one time unit after a rising edge and keeps `tx_valid` and `li_valid` asserted until a handshake completes. It sends whole frames with a header flag and mixes in only the deliberate stray and restart words of R9. The ready inputs are toggled from a pseudo-random sequence, so the hold properties see stalls of many lengths.

// File: rtl/msg_pkg.sv
package msg_pkg;
  typedef enum logic {
    SEND_IDLE,
    SEND_BUSY
  } send_state_e;
endpackage

// File: rtl/msg_addr_latch.sv
module msg_addr_latch #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_addr,
  output logic [ADDR_W-1:0] local_addr
);
  // Captured only while reset is held; no other path can write it.
  always_ff @(posedge clk) begin
    if (rst) local_addr <= cfg_addr;
  end
endmodule

// File: rtl/msg_tx_stamp.sv
module msg_tx_stamp
  import msg_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 16,
  parameter int MSG_WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           local_addr,
  input  logic                        tx_valid,
  output logic                        tx_ready,
  input  logic [MSG_WORDS*WORD_W-1:0] tx_msg,
  output logic                        lo_valid,
  input  logic                        lo_ready,
  output logic                        lo_sof,
  output logic [WORD_W-1:0]           lo_data
);
  localparam int IDX_W = (MSG_WORDS > 1) ? $clog2(MSG_WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MSG_WORDS - 1);

  send_state_e       st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] hold_q [MSG_WORDS];
  logic [WORD_W-1:0] header_w;
  logic              load;

  assign load = (st_q == SEND_IDLE) && tx_valid;

  // Header: keep the agent's target field, force the origin field.
  always_comb begin
    header_w = tx_msg[WORD_W-1:0];
    header_w[ADDR_W +: ADDR_W] = local_addr;
  end

  for (genvar g = 0; g < MSG_WORDS; g++) begin : g_hold
    if (g == 0) begin : g_hdr
      always_ff @(posedge clk) begin
        if (load) hold_q[g] <= header_w;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (load) hold_q[g] <= tx_msg[g*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SEND_IDLE;
      idx_q <= '0;
    end else begin
      case (st_q)
        SEND_IDLE: begin
          if (tx_valid) begin
            st_q  <= SEND_BUSY;
            idx_q <= '0;
          end
        end
        SEND_BUSY: begin
          if (lo_ready) begin
            if (idx_q == LAST_IDX) st_q <= SEND_IDLE;
            else                   idx_q <= idx_q + 1'b1;
          end
        end
        default: st_q <= SEND_IDLE;
      endcase
    end
  end

  assign tx_ready = (st_q == SEND_IDLE);
  assign lo_valid = (st_q == SEND_BUSY);
  assign lo_sof   = lo_valid && (idx_q == '0);
  assign lo_data  = hold_q[idx_q];
endmodule

// File: rtl/msg_rx_filter.sv
module msg_rx_filter #(
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 16,
  parameter int MSG_WORDS = 4,
  parameter int CNT_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           local_addr,
  input  logic                        li_valid,
  output logic                        li_ready,
  input  logic                        li_sof,
  input  logic [WORD_W-1:0]           li_data,
  output logic                        rx_valid,
  input  logic                        rx_ready,
  output logic [MSG_WORDS*WORD_W-1:0] rx_msg,
  output logic [ADDR_W-1:0]           rx_src,
  output logic [CNT_W-1:0]            drop_count
);
  localparam int IDX_W = (MSG_WORDS > 1) ? $clog2(MSG_WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MSG_WORDS - 1);

  logic [WORD_W-1:0]           asm_q [MSG_WORDS];
  logic [IDX_W-1:0]            idx_q;
  logic                        inframe_q;
  logic                        full_q;
  logic [MSG_WORDS*WORD_W-1:0] out_q;
  logic [CNT_W-1:0]            cnt_q;
  logic take, start, more, ends, hit;

  assign take  = li_valid && !full_q;
  assign start = take && li_sof;
  assign more  = take && !li_sof && inframe_q;
  assign ends  = more && (idx_q == LAST_IDX);
  assign hit   = (asm_q[0][ADDR_W-1:0] == local_addr);

  // Assembly storage: no reset, written at the frame position.
  always_ff @(posedge clk) begin
    if (start)             asm_q[0]     <= li_data;
    else if (more && !ends) asm_q[idx_q] <= li_data;
  end

  always_ff @(posedge clk) begin
    if (ends && hit) begin
      for (int k = 0; k < MSG_WORDS - 1; k++) out_q[k*WORD_W +: WORD_W] <= asm_q[k];
      out_q[(MSG_WORDS-1)*WORD_W +: WORD_W] <= li_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      inframe_q <= 1'b0;
      full_q    <= 1'b0;
      cnt_q     <= '0;
    end else begin
      if (start) begin
        idx_q     <= IDX_W'(1);
        inframe_q <= 1'b1;
      end else if (ends) begin
        idx_q     <= '0;
        inframe_q <= 1'b0;
        if (hit)              full_q <= 1'b1;
        else if (cnt_q != '1) cnt_q  <= cnt_q + 1'b1;
      end else if (more) begin
        idx_q <= idx_q + 1'b1;
      end
      if (full_q && rx_ready) full_q <= 1'b0;
    end
  end

  assign li_ready   = !full_q;
  assign rx_valid   = full_q;
  assign rx_msg     = out_q;
  assign rx_src     = out_q[ADDR_W +: ADDR_W];
  assign drop_count = cnt_q;
endmodule

// File: rtl/msg_endpoint.sv
module msg_endpoint #(
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 16,
  parameter int MSG_WORDS = 4,
  parameter int CNT_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           cfg_addr,
  input  logic                        tx_valid,
  output logic                        tx_ready,
  input  logic [MSG_WORDS*WORD_W-1:0] tx_msg,
  output logic                        lo_valid,
  input  logic                        lo_ready,
  output logic                        lo_sof,
  output logic [WORD_W-1:0]           lo_data,
  input  logic                        li_valid,
  output logic                        li_ready,
  input  logic                        li_sof,
  input  logic [WORD_W-1:0]           li_data,
  output logic                        rx_valid,
  input  logic                        rx_ready,
  output logic [MSG_WORDS*WORD_W-1:0] rx_msg,
  output logic [ADDR_W-1:0]           rx_src,
  output logic [CNT_W-1:0]            drop_count
);
  logic [ADDR_W-1:0] local_addr;

  msg_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .local_addr(local_addr)
  );

  msg_tx_stamp #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .MSG_WORDS(MSG_WORDS)) u_tx (
    .clk(clk), .rst(rst), .local_addr(local_addr),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_msg(tx_msg),
    .lo_valid(lo_valid), .lo_ready(lo_ready), .lo_sof(lo_sof), .lo_data(lo_data)
  );

  msg_rx_filter #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .MSG_WORDS(MSG_WORDS), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .local_addr(local_addr),
    .li_valid(li_valid), .li_ready(li_ready), .li_sof(li_sof), .li_data(li_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_msg(rx_msg), .rx_src(rx_src),
    .drop_count(drop_count)
  );
endmodule

// File: rtl/msg_endpoint_chk.sv
module msg_endpoint_chk #(
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 16,
  parameter int MSG_WORDS = 4,
  parameter int CNT_W     = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        tx_valid,
  input logic                        tx_ready,
  input logic                        lo_valid,
  input logic                        lo_ready,
  input logic                        lo_sof,
  input logic [WORD_W-1:0]           lo_data,
  input logic                        li_ready,
  input logic                        rx_valid,
  input logic                        rx_ready,
  input logic [MSG_WORDS*WORD_W-1:0] rx_msg,
  input logic [CNT_W-1:0]            drop_count,
  input logic [ADDR_W-1:0]           local_addr
);
  // R2
  src_stamp_chk: assert property (@(posedge clk) disable iff (rst)
    (lo_valid && lo_sof) |-> (lo_data[ADDR_W +: ADDR_W] == local_addr));

  // R3
  lo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lo_valid && !lo_ready) |=> (lo_valid && $stable(lo_data) && $stable(lo_sof)));

  // R4
  tx_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R4
  tx_excl_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> !lo_valid);

  // R5
  addr_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(local_addr));

  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_msg)));

  // R7
  drop_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(drop_count) |-> (drop_count == $past(drop_count) + 1'b1));

  // R8
  li_stall_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !li_ready);
endmodule

bind msg_endpoint msg_endpoint_chk #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .MSG_WORDS(MSG_WORDS), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/msg_endpoint_bench.sv
module msg_endpoint_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 3;
  localparam int CNT_MAX    = (1 << CNT_W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [15:0]  cfg_addr = 16'h8061;
  logic         tx_valid = 1'b0;
  logic         tx_ready;
  logic [127:0] tx_msg = '0;
  logic         lo_valid, lo_sof;
  logic         lo_ready = 1'b0;
  logic [31:0]  lo_data;
  logic         li_valid = 1'b0;
  logic         li_ready;
  logic         li_sof = 1'b0;
  logic [31:0]  li_data = '0;
  logic         rx_valid;
  logic         rx_ready = 1'b0;
  logic [127:0] rx_msg;
  logic [15:0]  rx_src;
  logic [CNT_W-1:0] drop_count;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_endpoint #(.CNT_W(CNT_W)) u_msg_endpoint (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_msg(tx_msg),
    .lo_valid(lo_valid), .lo_ready(lo_ready), .lo_sof(lo_sof), .lo_data(lo_data),
    .li_valid(li_valid), .li_ready(li_ready), .li_sof(li_sof), .li_data(li_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_msg(rx_msg), .rx_src(rx_src),
    .drop_count(drop_count)
  );

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [32:0]  txq [$];
  logic [31:0]  m_asm [4];
  int           m_idx = 0;
  bit           m_inframe = 0, m_full = 0, live = 0;
  logic [127:0] m_out = '0;
  int           m_drops = 0;
  logic [15:0]  m_local = '0;

  always @(negedge clk) begin
    if (live && !done) begin
      chk("R4", "tx_ready", 128'(tx_ready), 128'(txq.size() == 0));
      chk("R3", "lo_valid", 128'(lo_valid), 128'(txq.size() != 0));
      if (txq.size() != 0) begin
        chk("R2 R5 R10", "lo_data", 128'(lo_data), 128'(txq[0][31:0]));
        chk("R3", "lo_sof", 128'(lo_sof), 128'(txq[0][32]));
      end
      chk("R8", "li_ready", 128'(li_ready), 128'(!m_full));
      chk("R6", "rx_valid", 128'(rx_valid), 128'(m_full));
      if (m_full) begin
        chk("R6 R8", "rx_msg", rx_msg, m_out);
        chk("R6", "rx_src", 128'(rx_src), 128'(m_out[31:16]));
      end
      chk("R7 R9", "drop_count", 128'(drop_count), 128'(m_drops));
    end
    if (rst) begin
      txq.delete();
      m_idx = 0; m_inframe = 0; m_full = 0; m_drops = 0;
      m_local = cfg_addr;
      live = 1;
    end else begin
      if (txq.size() != 0) begin
        if (lo_ready) void'(txq.pop_front());
      end else if (tx_valid) begin
        txq.push_back({1'b1, tx_msg[31:16] & 16'h0 | m_local, tx_msg[15:0]});
        txq.push_back({1'b0, tx_msg[63:32]});
        txq.push_back({1'b0, tx_msg[95:64]});
        txq.push_back({1'b0, tx_msg[127:96]});
      end
      if (m_full) begin
        if (rx_ready) m_full = 0;
      end else if (li_valid) begin
        if (li_sof) begin
          m_asm[0] = li_data; m_idx = 1; m_inframe = 1;
        end else if (m_inframe) begin
          if (m_idx == 3) begin
            m_inframe = 0; m_idx = 0;
            if (m_asm[0][15:0] == m_local) begin
              m_full = 1;
              m_out = {li_data, m_asm[2], m_asm[1], m_asm[0]};
            end else if (m_drops < CNT_MAX) m_drops++;
          end else begin
            m_asm[m_idx] = li_data; m_idx++;
          end
        end
      end
    end
  end

  // ---------------- ready pattern generators ----------------
  logic [15:0] lfsr = 16'hACE1;
  bit lo_rand = 0, rx_rand = 0;
  bit lo_fix = 1, rx_fix = 1;
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    lo_ready = lo_rand ? lfsr[3] : lo_fix;
    rx_ready = rx_rand ? lfsr[7] : rx_fix;
  end

  // ---------------- drivers ----------------
  task automatic send_msg(input logic [15:0] spoof, input logic [15:0] dst,
                          input logic [31:0] w1, input logic [31:0] w2, input logic [31:0] w3);
    bit r;
    tx_msg = {w3, w2, w1, spoof, dst};
    tx_valid = 1'b1;
    forever begin
      @(negedge clk); r = tx_ready;
      @(posedge clk); #1;
      if (r) break;
    end
    tx_valid = 1'b0;
  endtask

  task automatic put_word(input logic sof, input logic [31:0] d);
    bit r;
    li_valid = 1'b1; li_sof = sof; li_data = d;
    forever begin
      @(negedge clk); r = li_ready;
      @(posedge clk); #1;
      if (r) break;
    end
    li_valid = 1'b0; li_sof = 1'b0;
  endtask

  task automatic put_frame(input logic [15:0] src, input logic [15:0] dst, input logic [31:0] seed);
    put_word(1'b1, {src, dst});
    put_word(1'b0, seed);
    put_word(1'b0, seed ^ 32'h5A5A_0001);
    put_word(1'b0, seed + 32'h0101_0101);
  endtask

  task automatic settle();
    while (txq.size() != 0 || m_full) begin
      @(posedge clk); #1;
    end
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "tx_ready", 128'(tx_ready), 128'(1));
    chk("R1", "lo_valid", 128'(lo_valid), 128'(0));
    chk("R1", "rx_valid", 128'(rx_valid), 128'(0));
    chk("R1", "li_ready", 128'(li_ready), 128'(1));
    chk("R1", "drop_count", 128'(drop_count), 128'(0));
    @(posedge clk); #1;

    // R2: spoofed origin is overwritten
    send_msg(16'hDEAD, 16'h8003, 32'h0100_0007, 32'h1111_2222, 32'h3333_4444);
    settle();

    // R5: address input changes after reset; R4 R10 back-to-back under stalls
    cfg_addr = 16'h1234;
    lo_rand = 1;
    send_msg(16'h0000, 16'h8004, 32'h0200_0001, 32'hA, 32'hB);
    send_msg(16'hFFFF, 16'h8040, 32'h0300_0002, 32'hC, 32'hD);
    send_msg(16'h8061, 16'h8060, 32'h0400_0003, 32'hE, 32'hF);
    settle();
    lo_rand = 0;

    // R6: matching frame delivered; R7: foreign frame dropped
    put_frame(16'h8040, 16'h8061, 32'h1000_0001);
    put_frame(16'h8040, 16'h8003, 32'h1000_0002);
    // R5: frame to the new cfg value must be dropped
    put_frame(16'h8040, 16'h1234, 32'h1000_0003);
    settle();
    chk("R5 R7", "drop_count after foreign frames", 128'(drop_count), 128'(2));

    // R8: agent stalls, second frame is held back, order kept
    rx_fix = 0;
    put_frame(16'h0101, 16'h8061, 32'h2000_0001);
    fork
      put_frame(16'h0202, 16'h8061, 32'h2000_0002);
      begin
        repeat (8) @(posedge clk);
        #1 rx_fix = 1;
      end
    join
    settle();

    // R9: stray word ignored, restart abandons partial frame
    put_word(1'b0, 32'hBAD0_0000);
    put_word(1'b1, {16'h0303, 16'h8003});
    put_word(1'b0, 32'hBAD0_0001);
    put_frame(16'h0404, 16'h8061, 32'h3000_0001);
    settle();
    chk("R9", "drop_count after stray/restart", 128'(drop_count), 128'(2));

    // R7: saturation
    for (int i = 0; i < 8; i++) put_frame(16'h0505, 16'h7000, 32'h4000_0000 + i);
    settle();
    chk("R7", "drop_count saturated", 128'(drop_count), 128'(CNT_MAX));

    // Concurrent traffic both ways with random readies
    lo_rand = 1; rx_rand = 1;
    fork
      for (int i = 0; i < 6; i++)
        send_msg(16'h1357, 16'h8000 + 16'(i), 32'h0500_0000 + i, 32'(i), 32'(i * 3));
      for (int i = 0; i < 6; i++)
        put_frame(16'h0600 + 16'(i), 16'h8061, 32'h5000_0000 + i);
    join
    lo_rand = 0; rx_rand = 0; lo_fix = 1; rx_fix = 1;
    settle();
    finish_run();
  end
endmodule